// File: doc/BRIEF.md
# Debounce Timer Allocation Engine

This block shares three programmable debounce timers among a bank of GPIO inputs. Software, or a higher-level sequencer, sends a request that names one input and a debounce period that has already been converted to clock cycles. A period of zero asks for debouncing on that input to be turned off. For a nonzero period the engine first detaches the input from any timer it already uses. It then reuses a timer whose programmed period equals the request, and only if there is none does it take a timer that nobody uses. The engine keeps a user count for each timer and a timer number for each input. It drives the timer period registers and the two per-input select vectors that the debounce filters decode.

A request is one cycle of `req_valid` while `busy` is low. The engine walks a small state machine and finishes with a one-cycle `rsp_valid` pulse that carries a result code and, on success, the timer used. The states are IDLE (waiting; a request moves to RELEASE for a nonzero period, to DISABLE for a zero period, and to RESPOND for an index out of range), RELEASE (detach any held timer, then MATCH), MATCH (an exact period hit goes to COMMIT, otherwise CLAIM), CLAIM (a free timer is loaded and the engine goes to COMMIT; with no free timer the input's mode is cleared and the engine goes to RESPOND), COMMIT (attach the input unless the user count is full, then RESPOND), DISABLE (detach or report nothing held, then RESPOND) and RESPOND (pulse the response, then IDLE).

If no timer can be had, the input is left with debouncing off. Its select bits then agree with its cleared map entry.

Top module: `dbt_alloc_engine`

## Requirements
- R1: After reset, every map entry, user count, timer period and select bit is zero, `busy` is low and `rsp_valid` is low.
- R2: A request is taken only when `req_valid` is high while `busy` is low. `busy` is high from the next cycle up to and including the response cycle. Requests raised while `busy` is high are ignored. `rsp_valid` is high for exactly one cycle per taken request.
- R3: Each input's timer number t (0 = no debounce, 1 to 3 = timer) is driven as two bits: bit 1 of t on `sel_hi[i]` and bit 0 of t on `sel_lo[i]`. While idle these always equal the input's map entry.
- R4: An enable request (nonzero period) first releases the timer the input holds, if any: that timer's user count drops by one and the input's map entry becomes 0, before any search.
- R5: After the release, timers 1, 2, 3 are searched in that order for a programmed period equal to the request. The first hit is used, even if its user count is zero.
- R6: With no hit, timers 1, 2, 3 are searched in that order for a user count of zero. The first such timer is loaded with the requested period, which appears on its field of `timer_period` (timer k at bits [k*CYC_W-1:(k-1)*CYC_W]).
- R7: With no hit and no free timer, the response code is 1 (exhausted), `rsp_timer` is 0, and the input's select bits and map entry are 0.
- R8: On success, the response code is 0, `rsp_timer` gives the chosen timer, the input's map entry and select bits become that timer, and its user count rises by one. Each user count always equals the number of inputs mapped to that timer.
- R9: A disable request (period 0) for an input with no timer returns code 2 and changes no select bit, period or count.
- R10: A disable request for an input that holds a timer returns code 0 with `rsp_timer` 0, decrements that timer's count and clears the input's select bits. The timer's period is kept.
- R11: If the chosen timer's user count is already at its maximum (2^CNT_W - 1), the response code is 3, `rsp_timer` is 0 and the input is left with select bits 0.
- R12: A request with `req_index` of NUM_IN or above returns code 4 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_index | input | IDX_W (6) | Input number addressed by the request |
| req_cycles | input | CYC_W (32) | Debounce period in clock cycles; 0 disables |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 3 | 0 ok, 1 exhausted, 2 nothing held, 3 user count full, 4 index out of range |
| rsp_timer | output | 2 | Timer assigned on success, else 0 |
| timer_period | output | 3*CYC_W (96) | Programmed periods of timers 1 to 3, timer 1 in the low field |
| sel_hi | output | NUM_IN (32) | Per-input bit 1 of the timer number |
| sel_lo | output | NUM_IN (32) | Per-input bit 0 of the timer number |

## Verification
The assertions rely on every transaction starting from reset with consistent counts and on requests arriving only through the `req_valid`/`busy` handshake, so that map entries, counts and select bits are only compared while the engine is idle. They also assume that no input can reach the commit step still holding a timer, which the release step guarantees. The stimulus issues each request for one cycle only after `busy` has dropped. It draws periods from a short list so that exact matches, exhaustion and count saturation all occur, and it draws indices slightly beyond the valid range. One directed case deliberately raises `req_valid` while the engine is busy to show that the stray request is dropped.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    // Two select bits per input give three usable timers plus "off".
    localparam int unsigned TSEL_W     = 2;
    localparam int unsigned NUM_TIMERS = (1 << TSEL_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_MATCH,
        ST_CLAIM,
        ST_COMMIT,
        ST_DISABLE,
        ST_RESPOND
    } dbt_state_t;

    typedef enum logic [2:0] {
        RC_OK         = 3'd0,
        RC_EXHAUSTED  = 3'd1,
        RC_NO_TIMER   = 3'd2,
        RC_USERS_FULL = 3'd3,
        RC_BAD_INDEX  = 3'd4
    } dbt_code_t;

endpackage

// File: rtl/dbt_timer_bank.sv
module dbt_timer_bank
    import dbt_pkg::*;
#(
    parameter int unsigned CYC_W = 32,
    parameter int unsigned CNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [TSEL_W-1:0]             load_sel,
    input  logic [CYC_W-1:0]              load_val,
    input  logic                          inc_en,
    input  logic [TSEL_W-1:0]             inc_sel,
    input  logic                          dec_en,
    input  logic [TSEL_W-1:0]             dec_sel,
    input  logic [CYC_W-1:0]              cmp_val,
    output logic [NUM_TIMERS*CYC_W-1:0]   period_flat,
    output logic [NUM_TIMERS*CNT_W-1:0]   users_flat,
    output logic                          hit_any,
    output logic [TSEL_W-1:0]             hit_sel,
    output logic                          free_any,
    output logic [TSEL_W-1:0]             free_sel,
    output logic [NUM_TIMERS-1:0]         full_vec
);

    logic [NUM_TIMERS-1:0] hit_vec;
    logic [NUM_TIMERS-1:0] free_vec;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        localparam logic [TSEL_W-1:0] TID = TSEL_W'(g + 1);

        logic [CYC_W-1:0] period_q;
        logic [CNT_W-1:0] users_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                period_q <= '0;
            end else if (load_en && (load_sel == TID)) begin
                period_q <= load_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                users_q <= '0;
            end else if (inc_en && (inc_sel == TID)) begin
                users_q <= users_q + 1'b1;
            end else if (dec_en && (dec_sel == TID)) begin
                users_q <= users_q - 1'b1;
            end
        end

        assign hit_vec[g]  = (period_q == cmp_val);
        assign free_vec[g] = (users_q == '0);
        assign full_vec[g] = &users_q;

        assign period_flat[g*CYC_W +: CYC_W] = period_q;
        assign users_flat[g*CNT_W +: CNT_W]  = users_q;
    end

    // Lowest-numbered candidate wins in both searches.
    always_comb begin
        hit_sel  = '0;
        free_sel = '0;
        for (int k = NUM_TIMERS - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit_sel = TSEL_W'(k + 1);
            end
            if (free_vec[k]) begin
                free_sel = TSEL_W'(k + 1);
            end
        end
    end

    assign hit_any  = |hit_vec;
    assign free_any = |free_vec;

endmodule

// File: rtl/dbt_map.sv
module dbt_map
    import dbt_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    localparam int unsigned MAP_IW = $clog2(NUM_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [MAP_IW-1:0]        wr_idx,
    input  logic [TSEL_W-1:0]        wr_val,
    input  logic [MAP_IW-1:0]        rd_idx,
    output logic [TSEL_W-1:0]        rd_val,
    output logic [NUM_IN*TSEL_W-1:0] map_flat
);

    logic [TSEL_W-1:0] ent_q [NUM_IN];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == MAP_IW'(g))) begin
                ent_q[g] <= wr_val;
            end
        end
        assign map_flat[g*TSEL_W +: TSEL_W] = ent_q[g];
    end

    assign rd_val = ent_q[rd_idx];

endmodule

// File: rtl/dbt_mode_regs.sv
module dbt_mode_regs
    import dbt_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    localparam int unsigned MAP_IW = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MAP_IW-1:0] wr_idx,
    input  logic [TSEL_W-1:0] wr_mode,
    output logic [NUM_IN-1:0] sel_hi,
    output logic [NUM_IN-1:0] sel_lo
);

    // The upper select vector holds bit 1 of the timer number and the
    // lower one bit 0; the filters decode the pair in that order.
    for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_hi[g] <= 1'b0;
                sel_lo[g] <= 1'b0;
            end else if (wr_en && (wr_idx == MAP_IW'(g))) begin
                sel_hi[g] <= wr_mode[1];
                sel_lo[g] <= wr_mode[0];
            end
        end
    end

endmodule

// File: rtl/dbt_alloc_engine.sv
module dbt_alloc_engine
    import dbt_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned CYC_W  = 32,
    parameter int unsigned CNT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [IDX_W-1:0]            req_index,
    input  logic [CYC_W-1:0]            req_cycles,
    output logic                        busy,
    output logic                        rsp_valid,
    output logic [2:0]                  rsp_code,
    output logic [TSEL_W-1:0]           rsp_timer,
    output logic [NUM_TIMERS*CYC_W-1:0] timer_period,
    output logic [NUM_IN-1:0]           sel_hi,
    output logic [NUM_IN-1:0]           sel_lo
);

    localparam int unsigned MAP_IW = $clog2(NUM_IN);
    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W + 1)'(NUM_IN);

    dbt_state_t state_q, state_d;

    logic [MAP_IW-1:0]  idx_q;
    logic [CYC_W-1:0]   cyc_q;
    dbt_code_t          code_q, code_d;
    logic               code_set;
    logic [TSEL_W-1:0]  pick_q, pick_d;
    logic               pick_set;

    logic               map_wr_en;
    logic [TSEL_W-1:0]  map_wr_val;
    logic [TSEL_W-1:0]  cur_map;
    logic [NUM_IN*TSEL_W-1:0] map_flat;

    logic               mode_wr_en;
    logic [TSEL_W-1:0]  mode_wr_val;

    logic               load_en;
    logic [TSEL_W-1:0]  load_sel;
    logic               inc_en;
    logic               dec_en;
    logic [TSEL_W-1:0]  dec_sel;

    logic [NUM_TIMERS*CNT_W-1:0] users_flat;
    logic               hit_any, free_any;
    logic [TSEL_W-1:0]  hit_sel, free_sel;
    logic [NUM_TIMERS-1:0] full_vec;
    logic               pick_full;
    logic               in_range;
    logic               accept;

    assign in_range = ({1'b0, req_index} < IDX_LIMIT);
    assign accept   = (state_q == ST_IDLE) && req_valid;

    // ------------------------------------------------------------------
    // Storage
    // ------------------------------------------------------------------
    dbt_timer_bank #(
        .CYC_W (CYC_W),
        .CNT_W (CNT_W)
    ) u_timers (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .load_sel    (load_sel),
        .load_val    (cyc_q),
        .inc_en      (inc_en),
        .inc_sel     (pick_q),
        .dec_en      (dec_en),
        .dec_sel     (dec_sel),
        .cmp_val     (cyc_q),
        .period_flat (timer_period),
        .users_flat  (users_flat),
        .hit_any     (hit_any),
        .hit_sel     (hit_sel),
        .free_any    (free_any),
        .free_sel    (free_sel),
        .full_vec    (full_vec)
    );

    dbt_map #(
        .NUM_IN (NUM_IN)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_wr_en),
        .wr_idx   (idx_q),
        .wr_val   (map_wr_val),
        .rd_idx   (idx_q),
        .rd_val   (cur_map),
        .map_flat (map_flat)
    );

    dbt_mode_regs #(
        .NUM_IN (NUM_IN)
    ) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_idx  (idx_q),
        .wr_mode (mode_wr_val),
        .sel_hi  (sel_hi),
        .sel_lo  (sel_lo)
    );

    always_comb begin
        pick_full = 1'b0;
        for (int k = 0; k < NUM_TIMERS; k++) begin
            if (pick_q == TSEL_W'(k + 1)) begin
                pick_full = full_vec[k];
            end
        end
    end

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cyc_q  <= '0;
            code_q <= RC_OK;
            pick_q <= '0;
        end else begin
            if (accept) begin
                idx_q  <= req_index[MAP_IW-1:0];
                cyc_q  <= req_cycles;
                pick_q <= '0;
            end
            if (pick_set) begin
                pick_q <= pick_d;
            end
            if (code_set) begin
                code_q <= code_d;
            end
        end
    end

    // ------------------------------------------------------------------
    // Next state
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!in_range) begin
                        state_d = ST_RESPOND;
                    end else if (req_cycles == '0) begin
                        state_d = ST_DISABLE;
                    end else begin
                        state_d = ST_RELEASE;
                    end
                end
            end
            ST_RELEASE: state_d = ST_MATCH;
            ST_MATCH:   state_d = hit_any ? ST_COMMIT : ST_CLAIM;
            ST_CLAIM:   state_d = free_any ? ST_COMMIT : ST_RESPOND;
            ST_COMMIT:  state_d = ST_RESPOND;
            ST_DISABLE: state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ------------------------------------------------------------------
    // Outputs and write strobes
    // ------------------------------------------------------------------
    always_comb begin
        busy        = (state_q != ST_IDLE);
        rsp_valid   = (state_q == ST_RESPOND);
        rsp_code    = code_q;
        rsp_timer   = (code_q == RC_OK) ? pick_q : '0;

        code_set    = 1'b0;
        code_d      = code_q;
        pick_set    = 1'b0;
        pick_d      = pick_q;
        map_wr_en   = 1'b0;
        map_wr_val  = '0;
        mode_wr_en  = 1'b0;
        mode_wr_val = '0;
        load_en     = 1'b0;
        load_sel    = '0;
        inc_en      = 1'b0;
        dec_en      = 1'b0;
        dec_sel     = cur_map;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !in_range) begin
                    code_set = 1'b1;
                    code_d   = RC_BAD_INDEX;
                end
            end
            ST_RELEASE: begin
                if (cur_map != '0) begin
                    dec_en     = 1'b1;
                    map_wr_en  = 1'b1;
                    map_wr_val = '0;
                end
            end
            ST_MATCH: begin
                if (hit_any) begin
                    pick_set = 1'b1;
                    pick_d   = hit_sel;
                end
            end
            ST_CLAIM: begin
                if (free_any) begin
                    load_en  = 1'b1;
                    load_sel = free_sel;
                    pick_set = 1'b1;
                    pick_d   = free_sel;
                end else begin
                    mode_wr_en  = 1'b1;
                    mode_wr_val = '0;
                    code_set    = 1'b1;
                    code_d      = RC_EXHAUSTED;
                end
            end
            ST_COMMIT: begin
                code_set = 1'b1;
                if (pick_full) begin
                    mode_wr_en  = 1'b1;
                    mode_wr_val = '0;
                    code_d      = RC_USERS_FULL;
                end else begin
                    map_wr_en   = 1'b1;
                    map_wr_val  = pick_q;
                    inc_en      = 1'b1;
                    mode_wr_en  = 1'b1;
                    mode_wr_val = pick_q;
                    code_d      = RC_OK;
                end
            end
            ST_DISABLE: begin
                code_set = 1'b1;
                if (cur_map == '0) begin
                    code_d = RC_NO_TIMER;
                end else begin
                    dec_en      = 1'b1;
                    map_wr_en   = 1'b1;
                    map_wr_val  = '0;
                    mode_wr_en  = 1'b1;
                    mode_wr_val = '0;
                    code_d      = RC_OK;
                end
            end
            ST_RESPOND: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dbt_alloc_checker.sv
module dbt_alloc_checker
    import dbt_pkg::*;
#(
    parameter int unsigned NUM_IN = 32,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned CYC_W  = 32,
    parameter int unsigned CNT_W  = 4,
    localparam int unsigned MAP_IW = $clog2(NUM_IN)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        busy,
    input logic                        rsp_valid,
    input logic [2:0]                  rsp_code,
    input logic [TSEL_W-1:0]           rsp_timer,
    input logic [NUM_TIMERS*CYC_W-1:0] timer_period,
    input logic [NUM_IN-1:0]           sel_hi,
    input logic [NUM_IN-1:0]           sel_lo,
    input logic [NUM_IN*TSEL_W-1:0]    map_flat,
    input logic [NUM_TIMERS*CNT_W-1:0] users_flat,
    input logic [MAP_IW-1:0]           idx_q,
    input logic [CYC_W-1:0]            cyc_q
);

    int unsigned       tally [NUM_TIMERS];
    int unsigned       users [NUM_TIMERS];
    logic [CYC_W-1:0]  chosen_period;
    logic [TSEL_W-1:0] idx_mode;
    logic [TSEL_W-1:0] idx_map;

    always_comb begin
        for (int t = 0; t < NUM_TIMERS; t++) begin
            tally[t] = 0;
            users[t] = int'(users_flat[t*CNT_W +: CNT_W]);
            for (int i = 0; i < NUM_IN; i++) begin
                if (map_flat[i*TSEL_W +: TSEL_W] == TSEL_W'(t + 1)) begin
                    tally[t] = tally[t] + 1;
                end
            end
        end
        chosen_period = '0;
        for (int k = 0; k < NUM_TIMERS; k++) begin
            if (rsp_timer == TSEL_W'(k + 1)) begin
                chosen_period = timer_period[k*CYC_W +: CYC_W];
            end
        end
        idx_mode = {sel_hi[idx_q], sel_lo[idx_q]};
        idx_map  = map_flat[idx_q*TSEL_W +: TSEL_W];
    end

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        assert_mode_matches_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> ({sel_hi[gi], sel_lo[gi]} == map_flat[gi*TSEL_W +: TSEL_W]));
    end

    for (genvar gt = 0; gt < NUM_TIMERS; gt++) begin : g_tm
        assert_user_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> (users[gt] == tally[gt]));
    end

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_at_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_success_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'(RC_OK) && rsp_timer != '0)
            |-> (chosen_period == cyc_q && idx_mode == rsp_timer && idx_map == rsp_timer));

    assert_exhaust_failsafe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'(RC_EXHAUSTED)) |-> (idx_mode == '0 && idx_map == '0));

    assert_full_failsafe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'(RC_USERS_FULL)) |-> (idx_mode == '0 && idx_map == '0));

    assert_no_timer_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'(RC_NO_TIMER))
            |-> ($stable(sel_hi) && $stable(sel_lo) && $stable(map_flat) && $stable(users_flat)));

    assert_bad_index_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'(RC_BAD_INDEX))
            |-> ($stable(sel_hi) && $stable(sel_lo) && $stable(timer_period) && $stable(users_flat)));

endmodule

bind dbt_alloc_engine dbt_alloc_checker #(
    .NUM_IN (NUM_IN),
    .IDX_W  (IDX_W),
    .CYC_W  (CYC_W),
    .CNT_W  (CNT_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_timer    (rsp_timer),
    .timer_period (timer_period),
    .sel_hi       (sel_hi),
    .sel_lo       (sel_lo),
    .map_flat     (map_flat),
    .users_flat   (users_flat),
    .idx_q        (idx_q),
    .cyc_q        (cyc_q)
);

// File: tb/tb_dbt_alloc_engine.sv
module tb_dbt_alloc_engine;

    localparam int NUM_IN   = 32;
    localparam int IDX_W    = 6;
    localparam int CYC_W    = 32;
    localparam int CNT_W    = 4;
    localparam int CNT_MAX  = (1 << CNT_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic [IDX_W-1:0]     req_index = '0;
    logic [CYC_W-1:0]     req_cycles = '0;
    logic                 busy;
    logic                 rsp_valid;
    logic [2:0]           rsp_code;
    logic [1:0]           rsp_timer;
    logic [3*CYC_W-1:0]   timer_period;
    logic [NUM_IN-1:0]    sel_hi;
    logic [NUM_IN-1:0]    sel_lo;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int              mmap [NUM_IN];
    int              mcnt [4];
    logic [CYC_W-1:0] mper [4];

    dbt_alloc_engine #(
        .NUM_IN (NUM_IN),
        .IDX_W  (IDX_W),
        .CYC_W  (CYC_W),
        .CNT_W  (CNT_W)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_index    (req_index),
        .req_cycles   (req_cycles),
        .busy         (busy),
        .rsp_valid    (rsp_valid),
        .rsp_code     (rsp_code),
        .rsp_timer    (rsp_timer),
        .timer_period (timer_period),
        .sel_hi       (sel_hi),
        .sel_lo       (sel_lo)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input int code);
        case (code)
            0:       return "R8";
            1:       return "R7";
            2:       return "R9";
            3:       return "R11";
            default: return "R12";
        endcase
    endfunction

    // Reference behaviour computed from the requirements.
    task automatic model_op(input int idx, input logic [CYC_W-1:0] cyc,
                            output int code, output int tsel);
        tsel = 0;
        if (idx >= NUM_IN) begin
            code = 4;
            return;
        end
        if (cyc == '0) begin
            if (mmap[idx] == 0) begin
                code = 2;
            end else begin
                mcnt[mmap[idx]] = mcnt[mmap[idx]] - 1;
                mmap[idx] = 0;
                code = 0;
            end
            return;
        end
        if (mmap[idx] != 0) begin
            mcnt[mmap[idx]] = mcnt[mmap[idx]] - 1;
            mmap[idx] = 0;
        end
        for (int k = 1; k <= 3; k++) begin
            if (tsel == 0 && mper[k] == cyc) tsel = k;
        end
        if (tsel == 0) begin
            for (int k = 1; k <= 3; k++) begin
                if (tsel == 0 && mcnt[k] == 0) begin
                    tsel = k;
                    mper[k] = cyc;
                end
            end
        end
        if (tsel == 0) begin
            code = 1;
        end else if (mcnt[tsel] == CNT_MAX) begin
            code = 3;
            tsel = 0;
        end else begin
            mmap[idx] = tsel;
            mcnt[tsel] = mcnt[tsel] + 1;
            code = 0;
        end
    endtask

    task automatic check_state(input string req);
        logic [NUM_IN-1:0] exp_hi;
        logic [NUM_IN-1:0] exp_lo;
        for (int i = 0; i < NUM_IN; i++) begin
            exp_hi[i] = mmap[i][1];
            exp_lo[i] = mmap[i][0];
        end
        chk("R3", {req, " sel_hi"}, 64'(sel_hi), 64'(exp_hi));
        chk("R3", {req, " sel_lo"}, 64'(sel_lo), 64'(exp_lo));
        for (int k = 1; k <= 3; k++) begin
            chk("R6", {req, " timer period"},
                64'(timer_period[(k-1)*CYC_W +: CYC_W]), 64'(mper[k]));
        end
    endtask

    task automatic do_op(input int idx, input logic [CYC_W-1:0] cyc,
                         input string req, input bit stray);
        int exp_code;
        int exp_t;
        int waited;
        model_op(idx, cyc, exp_code, exp_t);
        @(negedge clk);
        chk("R2", "idle before request", {62'd0, busy, rsp_valid}, 64'd0);
        req_valid  = 1'b1;
        req_index  = IDX_W'(idx);
        req_cycles = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "busy after accept", 64'(busy), 64'd1);
        if (stray) begin
            // A second request while busy must be dropped (R2).
            req_valid  = 1'b1;
            req_index  = IDX_W'(9);
            req_cycles = 32'd777;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (!rsp_valid && waited < 16) begin
            @(negedge clk);
            waited = waited + 1;
        end
        chk("R2", {req, " response seen"}, 64'(rsp_valid), 64'd1);
        chk(tag_for(exp_code), {req, " code"}, 64'(rsp_code), 64'(exp_code));
        chk(req, "rsp_timer", 64'(rsp_timer), 64'(exp_t));
        check_state(req);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h00C0FFEE);
        for (int i = 0; i < NUM_IN; i++) mmap[i] = 0;
        for (int k = 0; k < 4; k++) begin
            mcnt[k] = 0;
            mper[k] = '0;
        end

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", 64'(busy), 64'd0);
        chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 64'(busy), 64'd0);
        chk("R1", "periods after reset", 64'(timer_period[63:0]), 64'd0);
        chk("R1", "period 3 after reset", 64'(timer_period[95:64]), 64'd0);
        chk("R1", "select bits after reset", {sel_hi, sel_lo}, 64'd0);

        // Directed corner cases
        do_op(5, 32'd0,   "R9 disable unassigned", 1'b0);
        do_op(0, 32'd100, "R6 claim first free", 1'b0);
        do_op(1, 32'd100, "R5 reuse exact match", 1'b0);
        do_op(2, 32'd200, "R6 claim second", 1'b0);
        do_op(3, 32'd300, "R6 claim third", 1'b0);
        do_op(4, 32'd400, "R7 exhausted fresh input", 1'b0);
        do_op(0, 32'd400, "R7 exhausted after release", 1'b0);
        do_op(1, 32'd500, "R4 release then reclaim", 1'b0);
        do_op(2, 32'd0,   "R10 disable assigned", 1'b0);
        do_op(5, 32'd200, "R5 match idle timer", 1'b0);
        do_op(40, 32'd100, "R12 index out of range", 1'b0);
        do_op(32, 32'd0,   "R12 first invalid index", 1'b0);
        do_op(6, 32'd300, "R2 stray request ignored", 1'b1);
        for (int i = 7; i <= 19; i++) begin
            do_op(i, 32'd300, "R8 fill timer three", 1'b0);
        end
        do_op(20, 32'd300, "R11 user count full", 1'b0);
        do_op(3, 32'd300, "R4 re-request same period", 1'b0);

        // Constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int idx;
            int sel;
            logic [CYC_W-1:0] cyc;
            idx = int'($urandom_range(0, NUM_IN + 1));
            sel = int'($urandom_range(0, 7));
            cyc = (sel < 2) ? 32'd0 : CYC_W'(sel * 100);
            do_op(idx, cyc, "R8 random", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule